// File: doc/BRIEF.md
# Dual-Processor Hardware Semaphore

This block holds one lock bit shared by two embedded processors. Each processor reaches it through its own register port. The port has a write strobe, a read strobe and a 32-bit read-data bus. A write strobe carries no value. It asks the block to flip the writer's own ownership state: a processor takes the lock if the lock is free, and gives it up if it already holds it. A write from a processor that does not hold the lock is dropped while the other processor holds it.

A read returns a view private to the reader. Bit 0 is 1 only if that reader is the current owner, and all other bits are zero. To take the lock, software issues a write and then a read, and repeats the pair until the read returns nonzero. To give the lock up, the owner issues one more write.

Both processors may write in the same cycle while the lock is free. Processor 0 then wins and the request from processor 1 is lost. The lock state is a one-hot-or-zero vector with one bit per processor.

Top module: `hw_sem_pair`

## Requirements
- R1: After reset the lock is unowned, and both read-data buses are all zeros until the next read.
- R2: Bits 31 to 1 of both read-data buses are always zero.
- R3: A read strobe sampled at a clock edge loads bit 0 of that port's read data with 1 if that port owned the lock before the edge, and with 0 otherwise. The value is visible after that edge. A write in the same cycle does not affect the value the read returns.
- R4: A write strobe from a processor while the lock is free makes that processor the owner from the next cycle.
- R5: A write strobe from the owning processor frees the lock from the next cycle.
- R6: A write strobe from the processor that does not own the lock, while the other processor owns it, leaves the current owner unchanged.
- R7: If both write strobes are high in the same cycle while the lock is free, processor 0 becomes the owner and the request from processor 1 is dropped.
- R8: A read-data bus keeps its value in every cycle in which its read strobe is low.
- R9: The two processors never own the lock at the same time, so simultaneous reads never both return 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| p0_wr_i | input | 1 | Processor 0 write strobe (request to toggle its ownership) |
| p0_rd_i | input | 1 | Processor 0 read strobe |
| p0_rdata_o | output | 32 | Processor 0 read data; bit 0 = owns lock |
| p1_wr_i | input | 1 | Processor 1 write strobe (request to toggle its ownership) |
| p1_rd_i | input | 1 | Processor 1 read strobe |
| p1_rdata_o | output | 32 | Processor 1 read data; bit 0 = owns lock |

## Verification
The assertions check the following on every cycle:
- the one-hot-or-zero ownership vector;
- the zero reserved bits;
- the acquire, release, ignore and tie-break transitions of the lock state;
- the capture and hold behaviour of each read register.

Only the bench scenarios can show that the software protocol works end to end through the ports. In that protocol, a write followed by a read returns ownership, a losing processor keeps reading 0 until the owner releases, and a read issued in the same cycle as a write reports the state from before that write. Long random sequences of mixed strobes compare both read buses against a bench model of the lock.

// File: rtl/hw_sem_pkg.sv
package hw_sem_pkg;
  localparam int NUM_CPU = 2;
  localparam int REG_W   = 32;
  typedef logic [NUM_CPU-1:0] own_vec_t;
endpackage

// File: rtl/sem_next.sv
// Next-state arbitration for the lock: lowest index wins when free.
module sem_next
  import hw_sem_pkg::*;
(
  input  own_vec_t own_q_i,
  input  own_vec_t wr_i,
  output own_vec_t own_d_o
);
  always_comb begin
    own_d_o = own_q_i;
    if (own_q_i == '0) begin
      for (int i = NUM_CPU - 1; i >= 0; i--) begin
        if (wr_i[i]) begin
          own_d_o    = '0;
          own_d_o[i] = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < NUM_CPU; i++) begin
        if (own_q_i[i] && wr_i[i]) own_d_o = '0;
      end
    end
  end
endmodule

// File: rtl/sem_state.sv
module sem_state
  import hw_sem_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  own_vec_t own_d_i,
  output own_vec_t own_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q_o <= '0;
    else         own_q_o <= own_d_i;
  end
endmodule

// File: rtl/sem_rd_port.sv
// Per-processor read register; captures the pre-update ownership bit.
module sem_rd_port #(
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             own_i,
  output logic [REG_W-1:0] rdata_o
);
  logic own_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   own_rd_q <= 1'b0;
    else if (rd_i) own_rd_q <= own_i;
  end

  assign rdata_o = {{(REG_W-1){1'b0}}, own_rd_q};
endmodule

// File: rtl/hw_sem_pair.sv
module hw_sem_pair
  import hw_sem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             p0_wr_i,
  input  logic             p0_rd_i,
  output logic [REG_W-1:0] p0_rdata_o,
  input  logic             p1_wr_i,
  input  logic             p1_rd_i,
  output logic [REG_W-1:0] p1_rdata_o
);
  own_vec_t own_q, own_d, wr_vec, rd_vec;
  logic [NUM_CPU-1:0][REG_W-1:0] rdata_arr;

  assign wr_vec = {p1_wr_i, p0_wr_i};
  assign rd_vec = {p1_rd_i, p0_rd_i};

  sem_next u_next (
    .own_q_i (own_q),
    .wr_i    (wr_vec),
    .own_d_o (own_d)
  );

  sem_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .own_d_i (own_d),
    .own_q_o (own_q)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_rd
    sem_rd_port #(.REG_W(REG_W)) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_i    (rd_vec[g]),
      .own_i   (own_q[g]),
      .rdata_o (rdata_arr[g])
    );
  end

  assign p0_rdata_o = rdata_arr[0];
  assign p1_rdata_o = rdata_arr[1];
endmodule

// File: rtl/hw_sem_pair_chk.sv
module hw_sem_pair_chk
  import hw_sem_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             p0_wr_i,
  input logic             p1_wr_i,
  input logic             p0_rd_i,
  input logic             p1_rd_i,
  input own_vec_t         own_q,
  input logic [REG_W-1:0] p0_rdata_o,
  input logic [REG_W-1:0] p1_rdata_o
);
  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(own_q));

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p0_rdata_o[REG_W-1:1] == '0) && (p1_rdata_o[REG_W-1:1] == '0));

  assert_take_p0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == '0 && p0_wr_i) |=> (own_q == 2'b01));

  assert_take_p1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == '0 && p1_wr_i && !p0_wr_i) |=> (own_q == 2'b10));

  assert_tie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == '0 && p0_wr_i && p1_wr_i) |=> (own_q == 2'b01));

  assert_release_p0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q[0] && p0_wr_i) |=> (own_q == '0));

  assert_release_p1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q[1] && p1_wr_i) |=> (own_q == '0));

  assert_ignore_p1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q[0] && !p0_wr_i) |=> (own_q == 2'b01));

  assert_ignore_p0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q[1] && !p1_wr_i) |=> (own_q == 2'b10));

  assert_read_p0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p0_rd_i |=> (p0_rdata_o[0] == $past(own_q[0])));

  assert_read_p1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p1_rd_i |=> (p1_rdata_o[0] == $past(own_q[1])));

  assert_hold_p0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p0_rd_i |=> $stable(p0_rdata_o));

  assert_hold_p1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p1_rd_i |=> $stable(p1_rdata_o));
endmodule

bind hw_sem_pair hw_sem_pair_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .p0_wr_i    (p0_wr_i),
  .p1_wr_i    (p1_wr_i),
  .p0_rd_i    (p0_rd_i),
  .p1_rd_i    (p1_rd_i),
  .own_q      (own_q),
  .p0_rdata_o (p0_rdata_o),
  .p1_rdata_o (p1_rdata_o)
);

// File: tb/hw_sem_pair_bench.sv
module hw_sem_pair_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p0_wr = 1'b0, p0_rd = 1'b0, p1_wr = 1'b0, p1_rd = 1'b0;
  logic [31:0] p0_rdata, p1_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [1:0] own_m = 2'b00;
  logic exp0 = 1'b0, exp1 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_sem_pair u_hw_sem_pair (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .p0_wr_i    (p0_wr),
    .p0_rd_i    (p0_rd),
    .p0_rdata_o (p0_rdata),
    .p1_wr_i    (p1_wr),
    .p1_rd_i    (p1_rd),
    .p1_rdata_o (p1_rdata)
  );

  // Lock model from the requirements (R4..R7)
  function automatic logic [1:0] model_next(input logic [1:0] own, input logic w0, input logic w1);
    if (own == 2'b00) begin
      if (w0)      return 2'b01;
      else if (w1) return 2'b10;
      else         return 2'b00;
    end
    if (own == 2'b01) return w0 ? 2'b00 : 2'b01;
    return w1 ? 2'b00 : 2'b10;
  endfunction

  task automatic check_word(input string tag, input string port, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s rdata actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  task automatic step(input logic w0, input logic w1, input logic r0, input logic r1, input string tag);
    p0_wr = w0; p1_wr = w1; p0_rd = r0; p1_rd = r1;
    if (r0) exp0 = own_m[0];
    if (r1) exp1 = own_m[1];
    own_m = model_next(own_m, w0, w1);
    @(negedge clk);
    check_word(r0 ? tag : "R8", "p0", p0_rdata, {31'b0, exp0});
    check_word(r1 ? tag : "R8", "p1", p1_rdata, {31'b0, exp1});
    checks++;
    if (p0_rdata[31:1] != '0 || p1_rdata[31:1] != '0) begin
      failures++;
      $display("FAIL R2 reserved bits actual=%h/%h expected=0", p0_rdata[31:1], p1_rdata[31:1]);
    end
    if (r0 && r1) begin
      checks++;
      if (p0_rdata[0] && p1_rdata[0]) begin
        failures++;
        $display("FAIL R9 both owners actual=11 expected=not 11");
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EA4_0001));
    repeat (3) @(negedge clk);
    check_word("R1", "p0", p0_rdata, 32'h0);
    check_word("R1", "p1", p1_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_word("R1", "p0", p0_rdata, 32'h0);
    check_word("R1", "p1", p1_rdata, 32'h0);
    step(0, 0, 1, 1, "R1");

    step(1, 0, 0, 0, "R4");
    step(0, 0, 1, 1, "R4");
    step(0, 1, 0, 0, "R6");
    step(0, 0, 1, 1, "R6");
    step(0, 0, 0, 0, "R8");
    step(1, 0, 1, 0, "R3");
    step(0, 0, 1, 1, "R5");
    step(1, 1, 0, 0, "R7");
    step(0, 0, 1, 1, "R7");
    step(1, 1, 1, 1, "R5");
    step(0, 0, 1, 1, "R5");
    step(0, 1, 0, 0, "R4");
    step(1, 0, 1, 1, "R6");
    step(0, 0, 1, 1, "R6");
    step(0, 1, 1, 1, "R5");
    step(0, 0, 1, 1, "R9");

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0], r[1], r[2], r[3], "R3");
    end

    p0_wr = 0; p1_wr = 0; p0_rd = 0; p1_rd = 0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule